// File: doc/BRIEF.md
# Gamepad Port Register File

This block holds the processor-visible registers for two gamepad ports and one expansion port, plus a read-only identification byte. Each port owns an output register and a direction mask. Bit 6 of a port's output register drives that port's select line. The select line chooses which of two button groups appears on the shared port pins.

A read of a port's data offset returns a merged byte. Bits the direction mask marks as outputs echo the processor's written value. The remaining bits show the live, active-low pin levels of the chosen button group. The expansion port has no pad attached, so its pins read as zero.

Accesses arrive on a simple strobe bus with an 8-bit lane carrying the low data byte. A word access is steered to the byte address one above the one given. Reads return their result one clock after the strobe. Invalid accesses raise a one-cycle error pulse and change no register.

Top module: `gp_port_regs`

## Requirements
- R1: After reset all port output registers and direction masks are 0x00, `rdata_o` is 0x00, `err_o` is 0 and `sel_o` is 0.
- R2: A read of byte offset 0x01 returns bit 7 = `export_i`, bit 6 = `pal_i`, bit 5 = 1, bits 4..0 = 0.
- R3: With the port's output bit 6 at 1, pin bits 5..0 of a read carry, from bit 0 upward: up, down, left, right, B, C. Pad input vectors are ordered {start, A, C, B, right, left, down, up}, with bit 7 = start.
- R4: With output bit 6 at 0, pin bit 0 carries up, bit 1 carries down, bits 2 and 3 read 0, bit 4 carries A and bit 5 carries start.
- R5: Button inputs are active-low and are passed through unchanged, so a pressed button (input 0) reads as 0.
- R6: A data read returns (pins & ~mask) | (output & mask). Pin bits 7 and 6 are always 0.
- R7: Output registers sit at offsets 0x03/0x05/0x07 and direction masks at 0x09/0x0B/0x0D, for pad 0, pad 1 and expansion. Masks read back as written. `sel_o[p]` equals bit 6 of port p's output register and changes only on a write.
- R8: With `word_i` = 1 the access targets byte offset `addr_i`+1 and uses the 8-bit data lane.
- R9: The expansion port's pins read as all zeros, so its data read shows only the masked output bits.
- R10: A read whose effective offset is even, or is odd but holds no register, returns 0x00 and pulses `err_o` high for one cycle.
- R11: A write to any effective offset other than the six output and mask registers pulses `err_o` and changes no register.
- R12: `rdata_o` updates only in the cycle after a read strobe and holds its value across writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_i | input | 1 | Access strobe, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = word access (offset + 1) |
| addr_i | input | AW | Byte offset within the block |
| wdata_i | input | 8 | Write data (low byte lane) |
| pal_i | input | 1 | 50 Hz system indication for the version byte |
| export_i | input | 1 | Export region indication for the version byte |
| pad0_n_i | input | 8 | Pad 0 button levels, active-low, {start,A,C,B,right,left,down,up} |
| pad1_n_i | input | 8 | Pad 1 button levels, same order |
| rdata_o | output | 8 | Registered read data |
| err_o | output | 1 | One-cycle pulse on an invalid access |
| sel_o | output | 3 | Select line per port (pad 0, pad 1, expansion) |

## Verification
The bench drives the select line both ways with several button patterns. A design that swapped the two button groups, or let left and right leak into bits 2 and 3 with select low, would return the wrong pin byte. It programs direction masks that cover bit 6 and bit 7, where the pins carry nothing. A merge that ignored the mask, or inverted the pins, would show up there. It also checks word steering, even and empty offsets, writes to the read-only version byte, and register contents after rejected writes. A decoder that dropped the offset+1 rule or let a stray write land would be caught.

// File: rtl/gp_pkg.sv
package gp_pkg;
  // register and pin geometry
  localparam int unsigned REG_W   = 8;
  localparam int unsigned SEL_BIT = 6;
  // offsets expressed as (byte offset >> 1), odd byte only
  localparam int unsigned H_VER   = 0;
  localparam int unsigned H_DATA0 = 1;
  localparam int unsigned H_CTRL0 = 4;

  typedef enum logic [1:0] {
    RD_VER  = 2'd0,
    RD_DATA = 2'd1,
    RD_CTRL = 2'd2,
    RD_NONE = 2'd3
  } rd_kind_e;
endpackage

// File: rtl/gp_decode.sv
module gp_decode
  import gp_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned NP = 3,
  localparam int unsigned PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          acc_i,
  input  logic          wr_i,
  input  logic          word_i,
  input  logic [AW-1:0] addr_i,
  output rd_kind_e      rd_kind_o,
  output logic [PW-1:0] port_o,
  output logic [NP-1:0] data_we_o,
  output logic [NP-1:0] ctrl_we_o,
  output logic          bad_o
);
  logic [AW-1:0] eff;
  logic [AW-2:0] half;
  logic          odd;
  logic          hit_ver, hit_data, hit_ctrl;

  assign eff  = addr_i + AW'(word_i);
  assign half = eff[AW-1:1];
  assign odd  = eff[0];

  always_comb begin
    hit_ver  = odd && (int'(half) == H_VER);
    hit_data = 1'b0;
    hit_ctrl = 1'b0;
    port_o   = '0;
    for (int p = 0; p < NP; p++) begin
      if (odd && int'(half) == H_DATA0 + p) begin
        hit_data = 1'b1;
        port_o   = PW'(p);
      end
      if (odd && int'(half) == H_CTRL0 + p) begin
        hit_ctrl = 1'b1;
        port_o   = PW'(p);
      end
    end
  end

  always_comb begin
    if (hit_ver)       rd_kind_o = RD_VER;
    else if (hit_data) rd_kind_o = RD_DATA;
    else if (hit_ctrl) rd_kind_o = RD_CTRL;
    else               rd_kind_o = RD_NONE;
  end

  always_comb begin
    data_we_o = '0;
    ctrl_we_o = '0;
    if (acc_i && wr_i) begin
      for (int p = 0; p < NP; p++) begin
        data_we_o[p] = hit_data && (port_o == PW'(p));
        ctrl_we_o[p] = hit_ctrl && (port_o == PW'(p));
      end
    end
  end

  assign bad_o = acc_i && (wr_i ? !(hit_data || hit_ctrl)
                                : !(hit_ver || hit_data || hit_ctrl));
endmodule

// File: rtl/gp_port.sv
module gp_port
  import gp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_we_i,
  input  logic             ctrl_we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [7:0]       pins_n_i,
  output logic [REG_W-1:0] data_o,
  output logic [REG_W-1:0] ctrl_o,
  output logic [REG_W-1:0] rd_o,
  output logic             sel_o
);
  logic [REG_W-1:0] data_q, data_d;
  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic [REG_W-1:0] pins;

  // next state
  always_comb begin
    data_d = data_q;
    ctrl_d = ctrl_q;
    if (data_we_i) data_d = wdata_i;
    if (ctrl_we_i) ctrl_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
    end else begin
      data_q <= data_d;
      ctrl_q <= ctrl_d;
    end
  end

  // button group selection; pins are active-low and passed through
  always_comb begin
    if (data_q[SEL_BIT])
      pins = {2'b00, pins_n_i[5:0]};
    else
      pins = {2'b00, pins_n_i[7], pins_n_i[6], 2'b00, pins_n_i[1:0]};
  end

  assign rd_o   = (pins & ~ctrl_q) | (data_q & ctrl_q);
  assign data_o = data_q;
  assign ctrl_o = ctrl_q;
  assign sel_o  = data_q[SEL_BIT];

  // R4: with select low, unmasked bits 2..3 never read as 1
  a_r4_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_q[SEL_BIT] && ctrl_q[3:2] == 2'b00) |-> rd_o[3:2] == 2'b00);
endmodule

// File: rtl/gp_port_regs.sv
module gp_port_regs
  import gp_pkg::*;
#(
  parameter int unsigned AW   = 5,
  parameter int unsigned NPAD = 2,
  localparam int unsigned NP  = NPAD + 1,
  localparam int unsigned PW  = $clog2(NP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  logic             wr_i,
  input  logic             word_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             pal_i,
  input  logic             export_i,
  input  logic [7:0]       pad0_n_i,
  input  logic [7:0]       pad1_n_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             err_o,
  output logic [NP-1:0]    sel_o
);
  rd_kind_e         rd_kind;
  logic [PW-1:0]    port_idx;
  logic [NP-1:0]    data_we, ctrl_we;
  logic             dec_bad;
  logic [NPAD*8-1:0] pad_bus;
  logic [NP*REG_W-1:0] data_all, ctrl_all, rd_all;
  logic [REG_W-1:0] rdata_q, rdata_d;
  logic             rdata_en;
  logic             err_q, err_d;

  assign pad_bus = {pad1_n_i, pad0_n_i};

  gp_decode #(.AW(AW), .NP(NP)) u_dec (
    .acc_i     (acc_i),
    .wr_i      (wr_i),
    .word_i    (word_i),
    .addr_i    (addr_i),
    .rd_kind_o (rd_kind),
    .port_o    (port_idx),
    .data_we_o (data_we),
    .ctrl_we_o (ctrl_we),
    .bad_o     (dec_bad)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [7:0] pins_n;
    if (p < NPAD) begin : g_pad
      assign pins_n = pad_bus[p*8 +: 8];
    end else begin : g_exp
      assign pins_n = 8'h00;
    end
    gp_port u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .data_we_i (data_we[p]),
      .ctrl_we_i (ctrl_we[p]),
      .wdata_i   (wdata_i),
      .pins_n_i  (pins_n),
      .data_o    (data_all[p*REG_W +: REG_W]),
      .ctrl_o    (ctrl_all[p*REG_W +: REG_W]),
      .rd_o      (rd_all[p*REG_W +: REG_W]),
      .sel_o     (sel_o[p])
    );
  end

  // read data next state
  assign rdata_en = acc_i && !wr_i;

  always_comb begin
    rdata_d = rdata_q;
    if (rdata_en) begin
      rdata_d = '0;
      unique case (rd_kind)
        RD_VER: rdata_d = {export_i, pal_i, 1'b1, 5'b00000};
        RD_DATA: begin
          for (int p = 0; p < NP; p++)
            if (port_idx == PW'(p)) rdata_d = rd_all[p*REG_W +: REG_W];
        end
        RD_CTRL: begin
          for (int p = 0; p < NP; p++)
            if (port_idx == PW'(p)) rdata_d = ctrl_all[p*REG_W +: REG_W];
        end
        default: rdata_d = '0;
      endcase
    end
  end

  assign err_d = dec_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  // R2: version byte constant bits
  a_r2_version: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && !wr_i && !word_i && addr_i == AW'(1))
    |=> (rdata_o[5] == 1'b1 && rdata_o[4:0] == 5'd0 && !err_o));

  // R10: even byte read returns zero and flags an error
  a_r10_even_read: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && !wr_i && !word_i && !addr_i[0]) |=> (err_o && rdata_o == '0));

  // R11: rejected write leaves every register untouched
  a_r11_bad_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && wr_i && dec_bad) |=> ($stable(data_all) && $stable(ctrl_all) && err_o));

  // R12: read data holds unless a read strobe was seen
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_i && !wr_i) |=> $stable(rdata_o));

  // R7: select lines move only on writes
  a_r7_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_i && wr_i) |=> $stable(sel_o));
endmodule

// File: tb/tb_gp_port_regs.sv
module tb_gp_port_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_i, wr_i, word_i;
  logic [4:0] addr_i;
  logic [7:0] wdata_i;
  logic       pal_i, export_i;
  logic [7:0] pad0_n_i, pad1_n_i;
  logic [7:0] rdata_o;
  logic       err_o;
  logic [2:0] sel_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gp_port_regs dut (
    .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .wr_i(wr_i), .word_i(word_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .pal_i(pal_i), .export_i(export_i),
    .pad0_n_i(pad0_n_i), .pad1_n_i(pad1_n_i),
    .rdata_o(rdata_o), .err_o(err_o), .sel_o(sel_o)
  );

  // {wr, word, addr[4:0], wdata[7:0], pad0[7:0], pad1[7:0], exp_rd[7:0], exp_err}
  localparam int NV = 25;
  localparam logic [39:0] TBL [NV] = '{
    {1'b0,1'b0,5'h01,8'h00,8'hFF,8'hFF,8'h60,1'b0},
    {1'b1,1'b0,5'h03,8'h40,8'hFF,8'hFF,8'h60,1'b0},
    {1'b0,1'b0,5'h03,8'h00,8'hFF,8'hFF,8'h3F,1'b0},
    {1'b0,1'b0,5'h03,8'h00,8'hFA,8'hFF,8'h3A,1'b0},
    {1'b1,1'b0,5'h03,8'h00,8'hFF,8'hFF,8'h3A,1'b0},
    {1'b0,1'b0,5'h03,8'h00,8'h7E,8'hFF,8'h12,1'b0},
    {1'b0,1'b0,5'h03,8'h00,8'hB3,8'hFF,8'h23,1'b0},
    {1'b1,1'b0,5'h03,8'hC0,8'hFF,8'hFF,8'h23,1'b0},
    {1'b1,1'b0,5'h09,8'h41,8'hFF,8'hFF,8'h23,1'b0},
    {1'b0,1'b0,5'h03,8'h00,8'hFF,8'hFF,8'h7E,1'b0},
    {1'b0,1'b0,5'h09,8'h00,8'hFF,8'hFF,8'h41,1'b0},
    {1'b1,1'b1,5'h0A,8'h82,8'hFF,8'hFF,8'h41,1'b0},
    {1'b0,1'b1,5'h0A,8'h00,8'hFF,8'hFF,8'h82,1'b0},
    {1'b0,1'b0,5'h05,8'h00,8'hFF,8'h5A,8'h10,1'b0},
    {1'b1,1'b0,5'h07,8'hFF,8'hFF,8'hFF,8'h10,1'b0},
    {1'b1,1'b0,5'h0D,8'h0F,8'hFF,8'hFF,8'h10,1'b0},
    {1'b0,1'b0,5'h07,8'h00,8'hFF,8'hFF,8'h0F,1'b0},
    {1'b0,1'b0,5'h0D,8'h00,8'hFF,8'hFF,8'h0F,1'b0},
    {1'b0,1'b0,5'h02,8'h00,8'hFF,8'hFF,8'h00,1'b1},
    {1'b1,1'b0,5'h11,8'h55,8'hFF,8'hFF,8'h00,1'b1},
    {1'b0,1'b0,5'h03,8'h00,8'hFF,8'hFF,8'h7E,1'b0},
    {1'b1,1'b0,5'h01,8'hFF,8'hFF,8'hFF,8'h7E,1'b1},
    {1'b0,1'b0,5'h01,8'h00,8'hFF,8'hFF,8'h60,1'b0},
    {1'b0,1'b0,5'h1F,8'h00,8'hFF,8'hFF,8'h00,1'b1},
    {1'b0,1'b1,5'h03,8'h00,8'hFF,8'hFF,8'h00,1'b1}
  };
  string tags [NV] = '{
    "R2", "R12", "R3", "R5", "R12", "R4", "R4", "R12", "R7", "R6",
    "R7", "R8", "R8", "R6", "R9", "R9", "R9", "R7", "R10", "R11",
    "R11", "R11", "R2", "R10", "R8"
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic word, input logic [4:0] a,
                        input logic [7:0] d);
    @(negedge clk);
    acc_i = 1'b1; wr_i = wr; word_i = word; addr_i = a; wdata_i = d;
    @(negedge clk);
    acc_i = 1'b0; wr_i = 1'b0; word_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; acc_i = 1'b0; wr_i = 1'b0; word_i = 1'b0;
    addr_i = '0; wdata_i = '0; pal_i = 1'b1; export_i = 1'b0;
    pad0_n_i = 8'hFF; pad1_n_i = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rdata", rdata_o, 8'h00);
    chk("R1 err", {7'd0, err_o}, 8'h00);
    chk("R1 sel", {5'd0, sel_o}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      pad0_n_i = TBL[i][24:17];
      pad1_n_i = TBL[i][16:9];
      access(TBL[i][39], TBL[i][38], TBL[i][37:33], TBL[i][32:25]);
      chk(tags[i], rdata_o, TBL[i][8:1]);
      chk(tags[i], {7'd0, err_o}, {7'd0, TBL[i][0]});
    end

    // R7: select lines follow output bit 6 of each port
    chk("R7 sel", {5'd0, sel_o}, 8'h05);
    // R2: other region and frame-rate settings
    pal_i = 1'b0; export_i = 1'b1;
    access(1'b0, 1'b0, 5'h01, 8'h00);
    chk("R2 version", rdata_o, 8'hA0);
    // R12: idle cycle keeps read data
    @(negedge clk);
    chk("R12 idle", rdata_o, 8'hA0);

    // R1: reset mid-run clears registers
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 sel after reset", {5'd0, sel_o}, 8'h00);
    access(1'b0, 1'b0, 5'h09, 8'h00);
    chk("R1 mask after reset", rdata_o, 8'h00);
    pad0_n_i = 8'hFF;
    access(1'b0, 1'b0, 5'h03, 8'h00);
    chk("R1 R4 port after reset", rdata_o, 8'h33);
    // R9: expansion data with zero mask reads 0
    access(1'b0, 1'b0, 5'h07, 8'h00);
    chk("R9 expansion pins", rdata_o, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule